// File: doc/BRIEF.md
# Chained FIFO Segment Token Controller

This block joins several identical small FIFO segments into one deeper FIFO. Segments do not share one decoded address space. Instead, two independent tokens travel around a ring of segments: a write token and a read token. Only the segment that holds the write token accepts incoming words. Only the segment that holds the read token supplies outgoing words. When a segment fills its final storage location, it raises a one-cycle hand-off pulse to its successor, and the write token moves there. Reads hand off the read token in the same way when a segment's final location is read. The successor of the last segment is the first segment.

One segment is marked as the load segment by an active-low strap. After reset it holds both tokens. Combined full and empty are taken from the segments that currently hold the write and read tokens. When the block is built with a single segment there is no ring. The hand-off output of that segment then reports that it is more than half full.

Top module: `fifo_chain_ctrl`

## Requirements
- R1: While reset is active and after it is released, segment 0 holds both tokens (`wr_owner` and `rd_owner` equal one-hot bit 0), `empty` is 1, `full` is 0 and `rd_data` is 0.
- R2: A write (`wr_en`=1) is stored only in the segment that holds the write token. Words are stored in that segment's locations in ascending order.
- R3: `wr_pass[i]` is high for exactly the one cycle whose rising edge writes the last location of segment i. After that edge, `wr_owner` has moved from bit i to bit (i+1) mod NSEG.
- R4: `rd_pass[i]` is high for exactly the one cycle whose rising edge reads the last location of segment i. After that edge, `rd_owner` has moved from bit i to bit (i+1) mod NSEG.
- R5: A hand-off from the highest segment goes to segment 0, so both tokens circle the ring.
- R6: `full` is 1 exactly when the write-token segment holds DEPTH words. A write while `full` is 1 is dropped, and the stored contents and the tokens do not change.
- R7: `empty` is 1 exactly when the read-token segment holds no words. A read while `empty` is 1 leaves `rd_data` and the tokens unchanged.
- R8: After a read is accepted, the next word in write order appears on `rd_data` one rising edge later. `rd_data` then holds that word until the next accepted read.
- R9: A read and a write in the same cycle are both accepted, whether they fall in the same segment or in different segments.
- R10: With NSEG=1, `half_full` is 1 exactly when the segment holds more than DEPTH/2 words, and the tokens never move. With NSEG>1, `half_full` is 0.
- R11: At all times exactly one segment holds the write token and exactly one segment holds the read token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to write |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Registered read word |
| full | output | 1 | Write-token segment is full |
| empty | output | 1 | Read-token segment is empty |
| half_full | output | 1 | More than half full (NSEG=1 only) |
| wr_owner | output | NSEG | One-hot write-token holder |
| rd_owner | output | NSEG | One-hot read-token holder |
| wr_pass | output | NSEG | Write hand-off pulse of each segment |
| rd_pass | output | NSEG | Read hand-off pulse of each segment |

## Verification
The hand-off pulses are combinational in the cycle that performs the last-location access. The bench therefore samples them shortly after it applies the inputs, before the rising edge. Token ownership, `full`, `empty`, `half_full` and `rd_data` change at the rising edge that accepts the access. Each of these is due one edge after the stimulus and is sampled 1 ns after that edge. Reset release passes through a two-stage synchronizer, so the first stimulus is applied only after three further edges.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

  // predecessor of segment idx in a ring of n segments
  function automatic int unsigned ring_prev(input int unsigned idx, input int unsigned n);
    return (idx == 0) ? (n - 1) : (idx - 1);
  endfunction

endpackage

// File: rtl/fifo_chain_rstsync.sv
module fifo_chain_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign srst_n = out_q;

endmodule

// File: rtl/fifo_chain_seg.sv
module fifo_chain_seg #(
  parameter int unsigned DW      = 8,
  parameter int unsigned DEPTH   = 4,
  parameter bit          CHAINED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_n,
  input  logic          wxi,
  input  logic          rxi,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic [DW-1:0] wdata,
  output logic          wpass,
  output logic          rpass,
  output logic          wxo,
  output logic          seg_full,
  output logic          seg_empty,
  output logic          wtok,
  output logic          rtok,
  output logic          rd_acc,
  output logic [DW-1:0] qdata
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [CW-1:0] HALFC = CW'(DEPTH / 2);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_n;
  logic [AW-1:0] rptr_q, rptr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          wtok_q, wtok_n;
  logic          rtok_q, rtok_n;
  logic          wr_acc;

  assign seg_full  = (cnt_q == FULLC);
  assign seg_empty = (cnt_q == '0);
  assign wr_acc    = wtok_q && wr_req && !seg_full;
  assign rd_acc    = rtok_q && rd_req && !seg_empty;
  assign wpass     = CHAINED && wr_acc && (wptr_q == LAST);
  assign rpass     = CHAINED && rd_acc && (rptr_q == LAST);

  generate
    if (CHAINED) begin : g_chain_out
      assign wxo = wpass;
    end else begin : g_half_out
      assign wxo = (cnt_q > HALFC);
    end
  endgenerate

  assign wtok  = wtok_q;
  assign rtok  = rtok_q;
  assign qdata = rtok_q ? mem[rptr_q] : '0;

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    wtok_n = wtok_q;
    rtok_n = rtok_q;
    if (wr_acc) wptr_n = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    if (rd_acc) rptr_n = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    case ({wr_acc, rd_acc})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
    if (wpass) wtok_n = 1'b0;
    if (wxi)   wtok_n = 1'b1;
    if (rpass) rtok_n = 1'b0;
    if (rxi)   rtok_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      wtok_q <= !load_n;
      rtok_q <= !load_n;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
      wtok_q <= wtok_n;
      rtok_q <= rtok_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wptr_q] <= wdata;
  end

endmodule

// File: rtl/fifo_chain_ctrl.sv
module fifo_chain_ctrl #(
  parameter int unsigned NSEG  = 3,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_en,
  output logic [DW-1:0]   rd_data,
  output logic            full,
  output logic            empty,
  output logic            half_full,
  output logic [NSEG-1:0] wr_owner,
  output logic [NSEG-1:0] rd_owner,
  output logic [NSEG-1:0] wr_pass,
  output logic [NSEG-1:0] rd_pass
);

  localparam bit CHAINED = (NSEG > 1);

  logic            srst_n;
  logic [NSEG-1:0] wxo;
  logic [NSEG-1:0] seg_full;
  logic [NSEG-1:0] seg_empty;
  logic [NSEG-1:0] rd_acc;
  logic [DW-1:0]   qdata [NSEG];
  logic [DW-1:0]   q_or;
  logic [DW-1:0]   rd_q, rd_n;

  fifo_chain_rstsync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  generate
    for (genvar i = 0; i < NSEG; i++) begin : g_seg
      localparam int unsigned PREV = fifo_chain_pkg::ring_prev(i, NSEG);
      logic wxi_i;
      logic rxi_i;
      if (CHAINED) begin : g_ring
        assign wxi_i = wxo[PREV];
        assign rxi_i = rd_pass[PREV];
      end else begin : g_solo
        assign wxi_i = 1'b0;
        assign rxi_i = 1'b0;
      end
      fifo_chain_seg #(
        .DW      (DW),
        .DEPTH   (DEPTH),
        .CHAINED (CHAINED)
      ) u_seg (
        .clk       (clk),
        .rst_n     (srst_n),
        .load_n    (i != 0),
        .wxi       (wxi_i),
        .rxi       (rxi_i),
        .wr_req    (wr_en),
        .rd_req    (rd_en),
        .wdata     (wr_data),
        .wpass     (wr_pass[i]),
        .rpass     (rd_pass[i]),
        .wxo       (wxo[i]),
        .seg_full  (seg_full[i]),
        .seg_empty (seg_empty[i]),
        .wtok      (wr_owner[i]),
        .rtok      (rd_owner[i]),
        .rd_acc    (rd_acc[i]),
        .qdata     (qdata[i])
      );
    end
    if (CHAINED) begin : g_no_half
      assign half_full = 1'b0;
    end else begin : g_half
      assign half_full = wxo[0];
    end
  endgenerate

  assign full  = |(wr_owner & seg_full);
  assign empty = |(rd_owner & seg_empty);

  always_comb begin
    q_or = '0;
    for (int i = 0; i < NSEG; i++) q_or = q_or | qdata[i];
    rd_n = (|rd_acc) ? q_or : rd_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rd_q <= '0;
    else         rd_q <= rd_n;
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/fifo_chain_chk.sv
module fifo_chain_chk #(
  parameter int unsigned NSEG = 3,
  parameter int unsigned DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_en,
  input logic [DW-1:0]   rd_data,
  input logic            full,
  input logic            empty,
  input logic [NSEG-1:0] wr_owner,
  input logic [NSEG-1:0] rd_owner,
  input logic [NSEG-1:0] wr_pass,
  input logic [NSEG-1:0] rd_pass
);

  // R11
  one_wtoken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_owner) == 1);

  // R11
  one_rtoken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_owner) == 1);

  // R3
  wpass_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_pass) && ((wr_pass & ~wr_owner) == '0));

  // R4
  rpass_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_pass) && ((rd_pass & ~rd_owner) == '0));

  // R3
  wtoken_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_pass) |=> (wr_owner != $past(wr_owner)));

  // R2
  wtoken_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wr_pass) |=> $stable(wr_owner));

  // R4
  rtoken_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|rd_pass) |=> $stable(rd_owner));

  // R6
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !(|wr_pass));

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en) |=> $stable(rd_data));

endmodule

bind fifo_chain_ctrl fifo_chain_chk #(.NSEG(NSEG), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .full     (full),
  .empty    (empty),
  .wr_owner (wr_owner),
  .rd_owner (rd_owner),
  .wr_pass  (wr_pass),
  .rd_pass  (rd_pass)
);

// File: tb/fifo_chain_ctrl_bench.sv
module fifo_chain_ctrl_bench;

  localparam int unsigned NSEG  = 3;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned DW    = 8;
  localparam int unsigned NV    = 29;

  // row: we, wdata, re, wpass(pre-edge), rpass(pre-edge), wown, rown, full, empty, rd_data
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b1, 3'b000, 3'b000, 3'b001, 3'b001, 1'b0, 1'b1, 8'h00},
    {1'b1, 8'hA1, 1'b0, 3'b000, 3'b000, 3'b001, 3'b001, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'hA2, 1'b0, 3'b000, 3'b000, 3'b001, 3'b001, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'hA3, 1'b0, 3'b000, 3'b000, 3'b001, 3'b001, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'hA4, 1'b0, 3'b001, 3'b000, 3'b010, 3'b001, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'hA5, 1'b1, 3'b000, 3'b000, 3'b010, 3'b001, 1'b0, 1'b0, 8'hA1},
    {1'b1, 8'hA6, 1'b0, 3'b000, 3'b000, 3'b010, 3'b001, 1'b0, 1'b0, 8'hA1},
    {1'b1, 8'hA7, 1'b0, 3'b000, 3'b000, 3'b010, 3'b001, 1'b0, 1'b0, 8'hA1},
    {1'b1, 8'hA8, 1'b0, 3'b010, 3'b000, 3'b100, 3'b001, 1'b0, 1'b0, 8'hA1},
    {1'b1, 8'hA9, 1'b0, 3'b000, 3'b000, 3'b100, 3'b001, 1'b0, 1'b0, 8'hA1},
    {1'b1, 8'hAA, 1'b0, 3'b000, 3'b000, 3'b100, 3'b001, 1'b0, 1'b0, 8'hA1},
    {1'b1, 8'hAB, 1'b0, 3'b000, 3'b000, 3'b100, 3'b001, 1'b0, 1'b0, 8'hA1},
    {1'b1, 8'hAC, 1'b0, 3'b100, 3'b000, 3'b001, 3'b001, 1'b0, 1'b0, 8'hA1},
    {1'b1, 8'hAD, 1'b0, 3'b000, 3'b000, 3'b001, 3'b001, 1'b1, 1'b0, 8'hA1},
    {1'b1, 8'hAE, 1'b0, 3'b000, 3'b000, 3'b001, 3'b001, 1'b1, 1'b0, 8'hA1},
    {1'b0, 8'h00, 1'b1, 3'b000, 3'b000, 3'b001, 3'b001, 1'b0, 1'b0, 8'hA2},
    {1'b0, 8'h00, 1'b1, 3'b000, 3'b000, 3'b001, 3'b001, 1'b0, 1'b0, 8'hA3},
    {1'b0, 8'h00, 1'b1, 3'b000, 3'b001, 3'b001, 3'b010, 1'b0, 1'b0, 8'hA4},
    {1'b1, 8'hAF, 1'b1, 3'b000, 3'b000, 3'b001, 3'b010, 1'b0, 1'b0, 8'hA5},
    {1'b0, 8'h00, 1'b1, 3'b000, 3'b000, 3'b001, 3'b010, 1'b0, 1'b0, 8'hA6},
    {1'b0, 8'h00, 1'b1, 3'b000, 3'b000, 3'b001, 3'b010, 1'b0, 1'b0, 8'hA7},
    {1'b0, 8'h00, 1'b1, 3'b000, 3'b010, 3'b001, 3'b100, 1'b0, 1'b0, 8'hA8},
    {1'b0, 8'h00, 1'b1, 3'b000, 3'b000, 3'b001, 3'b100, 1'b0, 1'b0, 8'hA9},
    {1'b0, 8'h00, 1'b1, 3'b000, 3'b000, 3'b001, 3'b100, 1'b0, 1'b0, 8'hAA},
    {1'b0, 8'h00, 1'b1, 3'b000, 3'b000, 3'b001, 3'b100, 1'b0, 1'b0, 8'hAB},
    {1'b0, 8'h00, 1'b1, 3'b000, 3'b100, 3'b001, 3'b001, 1'b0, 1'b0, 8'hAC},
    {1'b0, 8'h00, 1'b1, 3'b000, 3'b000, 3'b001, 3'b001, 1'b0, 1'b0, 8'hAD},
    {1'b0, 8'h00, 1'b1, 3'b000, 3'b000, 3'b001, 3'b001, 1'b0, 1'b1, 8'hAF},
    {1'b0, 8'h00, 1'b1, 3'b000, 3'b000, 3'b001, 3'b001, 1'b0, 1'b1, 8'hAF}
  };

  logic            clk;
  logic            rst_n;
  logic            wr_en;
  logic [DW-1:0]   wr_data;
  logic            rd_en;
  logic [DW-1:0]   rd_data;
  logic            full;
  logic            empty;
  logic            half_full;
  logic [NSEG-1:0] wr_owner;
  logic [NSEG-1:0] rd_owner;
  logic [NSEG-1:0] wr_pass;
  logic [NSEG-1:0] rd_pass;

  logic            s_wr_en;
  logic [DW-1:0]   s_wr_data;
  logic            s_rd_en;
  logic [DW-1:0]   s_rd_data;
  logic            s_full;
  logic            s_empty;
  logic            s_half;
  logic [0:0]      s_wown;
  logic [0:0]      s_rown;
  logic [0:0]      s_wpass;
  logic [0:0]      s_rpass;

  int n_chk;
  int n_bad;
  bit done;
  logic [NSEG-1:0] wp_pre;
  logic [NSEG-1:0] rp_pre;

  fifo_chain_ctrl #(.NSEG(NSEG), .DEPTH(DEPTH), .DW(DW)) u_fifo_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .full(full), .empty(empty), .half_full(half_full),
    .wr_owner(wr_owner), .rd_owner(rd_owner), .wr_pass(wr_pass), .rd_pass(rd_pass)
  );

  fifo_chain_ctrl #(.NSEG(1), .DEPTH(DEPTH), .DW(DW)) u_single (
    .clk(clk), .rst_n(rst_n), .wr_en(s_wr_en), .wr_data(s_wr_data), .rd_en(s_rd_en),
    .rd_data(s_rd_data), .full(s_full), .empty(s_empty), .half_full(s_half),
    .wr_owner(s_wown), .rd_owner(s_rown), .wr_pass(s_wpass), .rd_pass(s_rpass)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // apply at falling edge, capture pulses before the rising edge, settle after it
  task automatic step(input logic we, input logic [DW-1:0] wd, input logic re);
    @(negedge clk);
    wr_en = we; wr_data = wd; rd_en = re;
    #1;
    wp_pre = wr_pass;
    rp_pre = rd_pass;
    @(posedge clk);
    #1;
  endtask

  task automatic sstep(input logic we, input logic [DW-1:0] wd, input logic re);
    @(negedge clk);
    s_wr_en = we; s_wr_data = wd; s_rd_en = re;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; s_wr_en = 1'b0; s_rd_en = 1'b0;
    rst_n = 1'b0;
    #1;
    // R1: values while reset is held
    chk("R1", "wr_owner in reset", 32'(wr_owner), 32'b001);
    chk("R1", "empty in reset", 32'(empty), 32'd1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    s_wr_en = 1'b0; s_wr_data = '0; s_rd_en = 1'b0;
    wp_pre = '0; rp_pre = '0;
    do_reset();

    // R1: state after reset release
    chk("R1", "wr_owner", 32'(wr_owner), 32'b001);
    chk("R1", "rd_owner", 32'(rd_owner), 32'b001);
    chk("R1", "full", 32'(full), 32'd0);
    chk("R1", "empty", 32'(empty), 32'd1);
    chk("R1", "rd_data", 32'(rd_data), 32'd0);
    // R10: multi-segment build keeps half_full low
    chk("R10", "half_full chained", 32'(half_full), 32'd0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int k = 0; k < NV; k++) begin
      logic [31:0] v;
      v = VEC[k];
      step(v[31], v[30:23], v[22]);
      chk("R3", $sformatf("wr_pass row %0d", k), 32'(wp_pre), 32'(v[21:19]));
      chk("R4", $sformatf("rd_pass row %0d", k), 32'(rp_pre), 32'(v[18:16]));
      chk("R5", $sformatf("wr_owner row %0d", k), 32'(wr_owner), 32'(v[15:13]));
      chk("R5", $sformatf("rd_owner row %0d", k), 32'(rd_owner), 32'(v[12:10]));
      chk("R6", $sformatf("full row %0d", k), 32'(full), 32'(v[9]));
      chk("R7", $sformatf("empty row %0d", k), 32'(empty), 32'(v[8]));
      chk("R8", $sformatf("rd_data row %0d", k), 32'(rd_data), 32'(v[7:0]));
    end

    // R1: reset in the middle of traffic clears stored words and tokens
    step(1'b1, 8'h5A, 1'b0);
    step(1'b1, 8'h5B, 1'b0);
    chk("R1", "empty before reset", 32'(empty), 32'd0);
    do_reset();
    chk("R1", "empty after mid reset", 32'(empty), 32'd1);
    chk("R1", "wr_owner after mid reset", 32'(wr_owner), 32'b001);
    chk("R1", "rd_data after mid reset", 32'(rd_data), 32'd0);

    // R9: read and write in the same segment in the same cycle
    step(1'b1, 8'h31, 1'b0);
    step(1'b1, 8'h32, 1'b1);
    chk("R9", "rd_data same-seg", 32'(rd_data), 32'h31);
    chk("R9", "empty same-seg", 32'(empty), 32'd0);
    step(1'b0, 8'h00, 1'b1);
    chk("R9", "rd_data second", 32'(rd_data), 32'h32);
    chk("R7", "empty drained", 32'(empty), 32'd1);

    // R10: single segment, half_full above DEPTH/2 words
    sstep(1'b1, 8'h11, 1'b0);
    chk("R10", "half_full at 1", 32'(s_half), 32'd0);
    sstep(1'b1, 8'h22, 1'b0);
    chk("R10", "half_full at 2", 32'(s_half), 32'd0);
    sstep(1'b1, 8'h33, 1'b0);
    chk("R10", "half_full at 3", 32'(s_half), 32'd1);
    sstep(1'b1, 8'h44, 1'b0);
    chk("R10", "single full", 32'(s_full), 32'd1);
    chk("R10", "single owner kept", 32'(s_wown), 32'd1);
    sstep(1'b0, 8'h00, 1'b1);
    chk("R8", "single rd_data", 32'(s_rd_data), 32'h11);
    chk("R10", "half_full at 3 after read", 32'(s_half), 32'd1);
    sstep(1'b0, 8'h00, 1'b1);
    chk("R10", "half_full at 2 after read", 32'(s_half), 32'd0);
    chk("R8", "single rd_data 2", 32'(s_rd_data), 32'h22);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

endmodule